// File: doc/BRIEF.md
# Branch Target Buffer Controller

This block is a small, fully associative branch target buffer with a control register. A fetch stage presents an address and the displacement sign of the branch at that address. In the same cycle the block answers with a hit flag, the stored target and a taken prediction. On a hit, the prediction comes from a 2-bit saturating counter held in the entry. On a miss, or while the buffer is disabled, a static rule picks the prediction from the branch direction.

Resolved branches come in on the update port. If the update address is already stored, only that entry's counter and target change. Otherwise a new entry is allocated, provided the buffer is enabled and the allocation policy admits that branch direction. The direction is always taken from the displacement sign bit, which is also true for absolute-addressed branches. A one-shot flash-invalidate bit in the control register clears every entry.

The victim for a new entry is the first invalid slot found by a round-robin search. When every slot is valid, the victim is the slot under the pointer.

Top module: `btb_unit`

## Requirements
- R1: After reset the control register reads 0 (enable 0, allocation policy 00, static policy 00) and every entry is invalid, so no lookup hits.
- R2: Writing a 1 to control bit 1 (flash invalidate) clears every entry at that clock edge, whether the enable bit is 0 or 1. Bit 1 always reads back as 0.
- R3: The allocation policy sits in control bits [3:2]. 00 allocates for both directions, 01 blocks backward branches (sign 1), 10 blocks forward branches (sign 0), and 11 blocks both. The policy never affects hits, or updates to entries that are already present.
- R4: The static policy sits in control bits [5:4] and decides the prediction on every miss. 00 predicts taken for both directions, 01 predicts taken only for forward branches, 10 predicts taken only for backward branches, and 11 predicts not taken for both. It applies whatever the enable bit is.
- R5: Control bit 0 is the enable bit. While it is 0 there are no hits, no allocations and no counter changes. Clearing it keeps the entries, so they hit again once the bit is set.
- R6: A new entry starts with its counter at 2 if the branch was taken and at 1 if it was not. Each update that hits moves the counter up (taken) or down (not taken), saturating at 3 and at 0. A hit predicts taken when the counter is 2 or 3.
- R7: Allocation takes the first invalid entry found by searching forward from the round-robin pointer, or the entry under the pointer when all entries are valid. The pointer then moves to the entry after the one used. An update that hits never allocates a second copy.
- R8: When a flash invalidate and an allocation fall on the same edge, the invalidate wins and the allocated branch does not hit afterwards.
- R9: An update that hits replaces the stored target with the update target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csrWrEn | input | 1 | Control register write strobe |
| csrWdata | input | 6 | Control register write data |
| csrRdata | output | 6 | Control register read data |
| lookupAddr | input | 32 | Fetch address to look up |
| lookupDispNeg | input | 1 | Displacement sign of the looked-up branch (1 = backward) |
| lookupHit | output | 1 | Lookup hit |
| lookupTarget | output | 32 | Predicted target on a hit, 0 otherwise |
| lookupTaken | output | 1 | Predicted taken |
| updValid | input | 1 | Resolved branch update strobe |
| updAddr | input | 32 | Resolved branch address |
| updTarget | input | 32 | Resolved branch target |
| updTaken | input | 1 | Resolved branch outcome |
| updDispNeg | input | 1 | Displacement sign of the resolved branch |

## Verification
The two functions that can fall in the same cycle are a flash invalidate, carried by a control write, and the allocation of a resolved branch. The bench drives a write of enable plus invalidate and an update for a new address on the same clock edge. It then judges the outcome at the lookup port: the new address must miss, and an address that was valid before the edge must miss as well. An update that hits while the allocation policy blocks its direction is a second overlap. The bench checks that it still rewrites the target.

// File: rtl/btb_pkg.sv
package btb_pkg;
  localparam int CSR_W    = 6;
  localparam int EN_BIT   = 0;
  localparam int INV_BIT  = 1;
  localparam int ALLOC_LO = 2;
  localparam int PRED_LO  = 4;

  typedef struct packed {
    logic enable;
    logic flush;
    logic allocOk;
    logic staticTaken;
  } btb_strobe_t;
endpackage

// File: rtl/btb_csr.sv
module btb_csr
  import btb_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             csrWrEn,
  input  logic [CSR_W-1:0] csrWdata,
  output logic [CSR_W-1:0] csrRdata,
  input  logic             lookupDispNeg,
  input  logic             updDispNeg,
  output btb_strobe_t      ctl
);
  logic       enableReg;
  logic [1:0] allocReg;
  logic [1:0] predReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableReg <= 1'b0;
      allocReg  <= 2'b00;
      predReg   <= 2'b00;
    end else if (csrWrEn) begin
      enableReg <= csrWdata[EN_BIT];
      allocReg  <= csrWdata[ALLOC_LO +: 2];
      predReg   <= csrWdata[PRED_LO +: 2];
    end
  end

  // invalidate bit is a strobe only; never stored
  assign csrRdata = {predReg, allocReg, 1'b0, enableReg};

  always_comb begin
    ctl.enable      = enableReg;
    ctl.flush       = csrWrEn & csrWdata[INV_BIT];
    // allocReg[0] blocks backward, allocReg[1] blocks forward
    ctl.allocOk     = enableReg & ~(updDispNeg ? allocReg[0] : allocReg[1]);
    // predReg[0] vetoes backward taken, predReg[1] vetoes forward taken
    ctl.staticTaken = lookupDispNeg ? ~predReg[0] : ~predReg[1];
  end

  assert_flash_reads_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    csrWrEn |=> (csrRdata[INV_BIT] == 1'b0));

  assert_enable_follows_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    csrWrEn |=> (csrRdata[EN_BIT] == $past(csrWdata[EN_BIT])));
endmodule

// File: rtl/btb_store.sv
module btb_store
  import btb_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  btb_strobe_t       ctl,
  input  logic [ADDR_W-1:0] lookupAddr,
  output logic              lookupHit,
  output logic [ADDR_W-1:0] lookupTarget,
  output logic              lookupTaken,
  input  logic              updValid,
  input  logic [ADDR_W-1:0] updAddr,
  input  logic [ADDR_W-1:0] updTarget,
  input  logic              updTaken
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] validVec;
  logic [ADDR_W-1:0]  tagMem [ENTRIES];
  logic [ADDR_W-1:0]  tgtMem [ENTRIES];
  logic [1:0]         ctrMem [ENTRIES];
  logic [IW-1:0]      rrPtr;

  logic [ENTRIES-1:0] lookHitVec;
  logic [ENTRIES-1:0] updHitVec;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_match
    assign lookHitVec[i] = ctl.enable & validVec[i] & (tagMem[i] == lookupAddr);
    assign updHitVec[i]  = ctl.enable & validVec[i] & (tagMem[i] == updAddr);
  end

  logic [1:0]    hitCtr;
  logic [IW-1:0] updIdx;
  logic          updHit;

  always_comb begin
    lookupTarget = '0;
    hitCtr       = 2'b00;
    updIdx       = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lookHitVec[i]) begin
        lookupTarget = tgtMem[i];
        hitCtr       = ctrMem[i];
      end
      if (updHitVec[i]) updIdx = IW'(i);
    end
  end

  assign lookupHit   = |lookHitVec;
  assign updHit      = |updHitVec;
  assign lookupTaken = lookupHit ? hitCtr[1] : ctl.staticTaken;

  // victim: first invalid slot searching forward from rrPtr, else rrPtr
  logic [IW-1:0] victim;
  logic          foundFree;
  always_comb begin
    victim    = rrPtr;
    foundFree = 1'b0;
    for (int k = 0; k < ENTRIES; k++) begin
      if (!foundFree && !validVec[IW'(rrPtr + IW'(k))]) begin
        victim    = IW'(rrPtr + IW'(k));
        foundFree = 1'b1;
      end
    end
  end

  logic [1:0] curCtr;
  assign curCtr = ctrMem[updIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validVec <= '0;
      rrPtr    <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tagMem[i] <= '0;
        tgtMem[i] <= '0;
        ctrMem[i] <= 2'b00;
      end
    end else if (ctl.flush) begin
      validVec <= '0;
    end else if (updValid && ctl.enable) begin
      if (updHit) begin
        tgtMem[updIdx] <= updTarget;
        if (updTaken && curCtr != 2'd3)       ctrMem[updIdx] <= curCtr + 2'd1;
        else if (!updTaken && curCtr != 2'd0) ctrMem[updIdx] <= curCtr - 2'd1;
      end else if (ctl.allocOk) begin
        validVec[victim] <= 1'b1;
        tagMem[victim]   <= updAddr;
        tgtMem[victim]   <= updTarget;
        ctrMem[victim]   <= updTaken ? 2'd2 : 2'd1;
        rrPtr            <= IW'(victim + IW'(1));
      end
    end
  end

  assert_no_hit_disabled_R5: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.enable |-> !lookupHit);

  assert_single_copy_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lookHitVec));

  assert_alloc_blocked_R3: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && ctl.enable && !updHit && !ctl.allocOk && !ctl.flush) |=> $stable(validVec));

  assert_flush_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.flush |=> (validVec == '0));
endmodule

// File: rtl/btb_unit.sv
module btb_unit
  import btb_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csrWrEn,
  input  logic [CSR_W-1:0]  csrWdata,
  output logic [CSR_W-1:0]  csrRdata,
  input  logic [ADDR_W-1:0] lookupAddr,
  input  logic              lookupDispNeg,
  output logic              lookupHit,
  output logic [ADDR_W-1:0] lookupTarget,
  output logic              lookupTaken,
  input  logic              updValid,
  input  logic [ADDR_W-1:0] updAddr,
  input  logic [ADDR_W-1:0] updTarget,
  input  logic              updTaken,
  input  logic              updDispNeg
);
  btb_strobe_t ctl;

  btb_csr u_csr (
    .clk(clk), .rstN(rstN), .csrWrEn(csrWrEn), .csrWdata(csrWdata),
    .csrRdata(csrRdata), .lookupDispNeg(lookupDispNeg),
    .updDispNeg(updDispNeg), .ctl(ctl)
  );

  btb_store #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_store (
    .clk(clk), .rstN(rstN), .ctl(ctl), .lookupAddr(lookupAddr),
    .lookupHit(lookupHit), .lookupTarget(lookupTarget),
    .lookupTaken(lookupTaken), .updValid(updValid), .updAddr(updAddr),
    .updTarget(updTarget), .updTaken(updTaken)
  );
endmodule

// File: tb/sim_btb_unit.sv
`timescale 1ns/1ps
module sim_btb_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csrWrEn = 1'b0;
  logic [5:0]  csrWdata = '0;
  logic [5:0]  csrRdata;
  logic [31:0] lookupAddr = '0;
  logic        lookupDispNeg = 1'b0;
  logic        lookupHit;
  logic [31:0] lookupTarget;
  logic        lookupTaken;
  logic        updValid = 1'b0;
  logic [31:0] updAddr = '0;
  logic [31:0] updTarget = '0;
  logic        updTaken = 1'b0;
  logic        updDispNeg = 1'b0;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  btb_unit u0 (.*);

  // {static policy[1:0], displacement sign, expected taken}
  localparam logic [3:0] STATIC_TBL [8] = '{
    4'b0001, 4'b0011, 4'b0101, 4'b0110,
    4'b1000, 4'b1011, 4'b1100, 4'b1110
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic csrWrite(logic [5:0] d);
    @(negedge clk); csrWrEn = 1'b1; csrWdata = d;
    @(negedge clk); csrWrEn = 1'b0;
  endtask

  task automatic update(logic [31:0] a, logic [31:0] t, logic tk, logic neg);
    @(negedge clk);
    updValid = 1'b1; updAddr = a; updTarget = t; updTaken = tk; updDispNeg = neg;
    @(negedge clk); updValid = 1'b0;
  endtask

  task automatic look(logic [31:0] a, logic neg);
    lookupAddr = a; lookupDispNeg = neg; #1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 csr", 32'(csrRdata), 32'h0);
    look(32'h100, 1'b0);
    check("R1 hit", 32'(lookupHit), 0);

    // R4 static table, buffer disabled
    for (int i = 0; i < 8; i++) begin
      csrWrite({STATIC_TBL[i][3:2], 4'b0000});
      look(32'h500, STATIC_TBL[i][1]);
      check("R4 static taken", 32'(lookupTaken), 32'(STATIC_TBL[i][0]));
      check("R4 miss", 32'(lookupHit), 0);
    end

    // R5 no allocation while disabled
    csrWrite(6'h00);
    update(32'h100, 32'h200, 1'b1, 1'b0);
    csrWrite(6'h01);
    check("R2 csr read", 32'(csrRdata), 32'h01);
    look(32'h100, 1'b0);
    check("R5 no alloc when disabled", 32'(lookupHit), 0);

    // R6 allocation and counter
    update(32'h100, 32'h200, 1'b1, 1'b0);
    look(32'h100, 1'b0);
    check("R6 hit", 32'(lookupHit), 1);
    check("R6 target", lookupTarget, 32'h200);
    check("R6 taken init", 32'(lookupTaken), 1);
    update(32'h100, 32'h240, 1'b0, 1'b0);
    look(32'h100, 1'b0);
    check("R9 target replaced", lookupTarget, 32'h240);
    check("R6 ctr1 not taken", 32'(lookupTaken), 0);
    update(32'h100, 32'h240, 1'b0, 1'b0);
    update(32'h100, 32'h240, 1'b0, 1'b0);
    look(32'h100, 1'b0);
    check("R6 low saturation", 32'(lookupTaken), 0);
    update(32'h100, 32'h240, 1'b1, 1'b0);
    look(32'h100, 1'b0);
    check("R6 ctr1 after sat", 32'(lookupTaken), 0);
    for (int i = 0; i < 3; i++) update(32'h100, 32'h240, 1'b1, 1'b0);
    look(32'h100, 1'b0);
    check("R6 high saturation", 32'(lookupTaken), 1);
    update(32'h100, 32'h240, 1'b0, 1'b0);
    look(32'h100, 1'b0);
    check("R6 ctr2 after sat", 32'(lookupTaken), 1);

    // R3 allocation policy
    csrWrite(6'h05);
    update(32'h300, 32'h1, 1'b1, 1'b1);
    update(32'h304, 32'h2, 1'b1, 1'b0);
    look(32'h300, 1'b1); check("R3 01 blocks backward", 32'(lookupHit), 0);
    look(32'h304, 1'b0); check("R3 01 allows forward", 32'(lookupHit), 1);
    csrWrite(6'h09);
    update(32'h308, 32'h3, 1'b1, 1'b0);
    update(32'h30C, 32'h4, 1'b1, 1'b1);
    look(32'h308, 1'b0); check("R3 10 blocks forward", 32'(lookupHit), 0);
    look(32'h30C, 1'b1); check("R3 10 allows backward", 32'(lookupHit), 1);
    csrWrite(6'h0D);
    update(32'h310, 32'h5, 1'b1, 1'b0);
    update(32'h314, 32'h6, 1'b1, 1'b1);
    look(32'h310, 1'b0); check("R3 11 blocks forward", 32'(lookupHit), 0);
    look(32'h314, 1'b1); check("R3 11 blocks backward", 32'(lookupHit), 0);
    update(32'h100, 32'h280, 1'b1, 1'b1);
    look(32'h100, 1'b1);
    check("R3 hit unaffected", 32'(lookupHit), 1);
    check("R3 hit update under block", lookupTarget, 32'h280);

    // R5 disable keeps entries
    csrWrite(6'h00);
    look(32'h100, 1'b0);
    check("R5 disabled no hit", 32'(lookupHit), 0);
    check("R4 static when disabled", 32'(lookupTaken), 1);
    csrWrite(6'h01);
    look(32'h100, 1'b0);
    check("R5 re-enabled hit", 32'(lookupHit), 1);
    check("R5 target kept", lookupTarget, 32'h280);

    // R2 flash invalidate while disabled
    csrWrite(6'h02);
    check("R2 invalidate reads 0", 32'(csrRdata), 32'h00);
    csrWrite(6'h01);
    look(32'h100, 1'b0); check("R2 entry cleared", 32'(lookupHit), 0);
    look(32'h304, 1'b0); check("R2 second entry cleared", 32'(lookupHit), 0);

    // R7 round robin replacement, no duplicate
    for (int i = 0; i < 8; i++) update(32'h1000 + 32'(4 * i), 32'h9000 + 32'(i), 1'b1, 1'b0);
    update(32'h1004, 32'h9001, 1'b1, 1'b0);
    update(32'h1020, 32'h9008, 1'b1, 1'b0);
    look(32'h1000, 1'b0); check("R7 oldest evicted", 32'(lookupHit), 0);
    for (int i = 1; i < 9; i++) begin
      look(32'h1000 + 32'(4 * i), 1'b0);
      check("R7 retained", 32'(lookupHit), 1);
      check("R7 target", lookupTarget, 32'h9000 + 32'(i));
    end

    // R8 invalidate and allocation on the same edge
    @(negedge clk);
    csrWrEn = 1'b1; csrWdata = 6'h03;
    updValid = 1'b1; updAddr = 32'h2000; updTarget = 32'h7; updTaken = 1'b1; updDispNeg = 1'b0;
    @(negedge clk);
    csrWrEn = 1'b0; updValid = 1'b0;
    look(32'h2000, 1'b0); check("R8 alloc dropped", 32'(lookupHit), 0);
    look(32'h1004, 1'b0); check("R8 old entry cleared", 32'(lookupHit), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule